// File: doc/BRIEF.md
# Crossing-Time Mismatch Fault Detector

This block sits behind four external threshold comparators that slice two sinusoids: a known-good reference waveform and the response of the circuit under test. Each clock cycle it receives one synchronous sample per comparator: the reference above the upper threshold, the reference below the lower threshold, the response above the upper threshold and the response below the lower threshold. A cycle in which either pair of samples disagrees raises a fault flag that stays set until software-independent logic clears it with a synchronous clear.

The block also measures how many cycles each threshold pair disagrees during one reference period. A period starts at every rising edge of the reference upper-threshold sample. At each period start, the two counts from the period just finished are published together with a class code. The class code separates a balanced deviation (amplitude or phase) from a lopsided one (DC shift or frequency change), and it marks a response that never reached one of the thresholds as a gross fault. A tolerance input sets how far apart the two counts may be and still count as balanced.

Top module: `xing_fault_detector`

## Requirements
- R1: A cycle in which `ref_hi_i` differs from `dut_hi_i`, or `ref_lo_i` differs from `dut_lo_i`, sets `fault_o` high from the next clock edge on; `fault_o` does not rise while the samples agree.
- R2: `fault_o` stays high until `clr_i` is sampled high, which forces it low at the next edge; when `clr_i` and a mismatch arrive in the same cycle, the clear wins.
- R3: After reset `fault_o` is 0, both counts are 0 and `class_o` is 0.
- R4: A period begins in a cycle where `ref_hi_i` is 1 and was 0 in the previous cycle; that cycle belongs to the new period. One cycle after a period start, `hi_count_o` and `lo_count_o` show the number of mismatching cycles of the upper and lower pairs in the period just finished, and they hold that value until the next period start.
- R5: The first period start after reset only begins measurement; outputs keep their reset values through it, and mismatches seen before it are never reported in the counts.
- R6: Each count saturates at 2^CNT_W-1 instead of wrapping.
- R7: `class_o` = 1 (balanced) when both thresholds were crossed by the response, the counts are not both zero, and their absolute difference is at most `tol_i` (equality of difference and tolerance counts as balanced).
- R8: Otherwise, with both thresholds crossed, `class_o` = 2 when the upper count is the larger (DC drop or higher frequency) and 3 when the lower count is the larger (DC rise or lower frequency).
- R9: `class_o` = 4 when, during the finished period, `dut_hi_i` was never 1 or `dut_lo_i` was never 1; this takes priority over every other code.
- R10: `class_o` = 0 when both counts of the finished period are zero and both thresholds were crossed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the sticky fault flag |
| ref_hi_i | input | 1 | Reference above upper threshold |
| ref_lo_i | input | 1 | Reference below lower threshold |
| dut_hi_i | input | 1 | Response above upper threshold |
| dut_lo_i | input | 1 | Response below lower threshold |
| tol_i | input | CNT_W | Largest count difference still treated as balanced |
| fault_o | output | 1 | Sticky fault flag |
| hi_count_o | output | CNT_W | Upper-threshold mismatch cycles of the last period |
| lo_count_o | output | CNT_W | Lower-threshold mismatch cycles of the last period |
| class_o | output | 3 | Deviation class of the last period (0..4) |

## Verification
The bench builds the block with its default count width of 8 bits, so the saturation limit of 255 is reached with one stretched 300-cycle period in which the response sits below the lower threshold throughout. Ordinary periods of 20 cycles keep every count small, which lets the tolerance input be stepped across the exact difference of two counts to hit the balanced/lopsided boundary from both sides. A run of mismatching cycles before the first period start exposes any report of pre-measurement activity.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
    typedef enum logic [2:0] {
        CLS_NONE     = 3'd0,
        CLS_EQUAL    = 3'd1,
        CLS_HI_MORE  = 3'd2,
        CLS_LO_MORE  = 3'd3,
        CLS_NO_CROSS = 3'd4
    } xfd_class_e;

    // Index of each threshold in the per-level arrays.
    localparam int unsigned XFD_LVL_HI = 0;
    localparam int unsigned XFD_LVL_LO = 1;
    localparam int unsigned XFD_NUM_LVL = 2;
endpackage

// File: rtl/xfd_mismatch.sv
module xfd_mismatch
    import xfd_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   clr_i,
    input  logic [XFD_NUM_LVL-1:0] ref_i,
    input  logic [XFD_NUM_LVL-1:0] dut_i,
    output logic [XFD_NUM_LVL-1:0] miss_o,
    output logic                   fault_o
);
    typedef struct packed {
        logic fault;
    } mm_state_t;

    mm_state_t st_d, st_q;

    always_comb begin
        miss_o = ref_i ^ dut_i;
        st_d   = st_q;
        if (clr_i) begin
            st_d.fault = 1'b0;
        end else if (|miss_o) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;
endmodule

// File: rtl/xfd_span_counter.sv
module xfd_span_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             miss_i,
    input  logic             dut_i,
    output logic [CNT_W-1:0] count_o,
    output logic             seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic             seen;
    } span_state_t;

    span_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.acc  = miss_i ? CNT_ONE : '0;
            st_d.seen = dut_i;
        end else begin
            if (miss_i && (st_q.acc != CNT_MAX)) begin
                st_d.acc = st_q.acc + CNT_ONE;
            end
            st_d.seen = st_q.seen | dut_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.acc;
    assign seen_o  = st_q.seen;
endmodule

// File: rtl/xfd_classifier.sv
module xfd_classifier
    import xfd_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic [CNT_W-1:0] tol_i,
    input  logic             hi_seen_i,
    input  logic             lo_seen_i,
    output xfd_class_e       class_o
);
    logic             hi_more;
    logic [CNT_W-1:0] gap;

    always_comb begin
        hi_more = hi_cnt_i > lo_cnt_i;
        gap     = hi_more ? (hi_cnt_i - lo_cnt_i) : (lo_cnt_i - hi_cnt_i);
        if (!hi_seen_i || !lo_seen_i) begin
            class_o = CLS_NO_CROSS;
        end else if ((hi_cnt_i == '0) && (lo_cnt_i == '0)) begin
            class_o = CLS_NONE;
        end else if (gap <= tol_i) begin
            class_o = CLS_EQUAL;
        end else if (hi_more) begin
            class_o = CLS_HI_MORE;
        end else begin
            class_o = CLS_LO_MORE;
        end
    end
endmodule

// File: rtl/xing_fault_detector.sv
module xing_fault_detector
    import xfd_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             ref_hi_i,
    input  logic             ref_lo_i,
    input  logic             dut_hi_i,
    input  logic             dut_lo_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] hi_count_o,
    output logic [CNT_W-1:0] lo_count_o,
    output logic [2:0]       class_o
);
    typedef struct packed {
        logic             ref_prev;
        logic             armed;
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] lo_cnt;
        xfd_class_e       cls;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [XFD_NUM_LVL-1:0] ref_bits;
    logic [XFD_NUM_LVL-1:0] dut_bits;
    logic [XFD_NUM_LVL-1:0] miss;
    logic [CNT_W-1:0]       span_cnt  [XFD_NUM_LVL];
    logic                   span_seen [XFD_NUM_LVL];
    logic                   period_start;
    xfd_class_e             next_cls;

    assign ref_bits[XFD_LVL_HI] = ref_hi_i;
    assign ref_bits[XFD_LVL_LO] = ref_lo_i;
    assign dut_bits[XFD_LVL_HI] = dut_hi_i;
    assign dut_bits[XFD_LVL_LO] = dut_lo_i;

    assign period_start = ref_hi_i & ~st_q.ref_prev;

    xfd_mismatch u_mismatch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .ref_i   (ref_bits),
        .dut_i   (dut_bits),
        .miss_o  (miss),
        .fault_o (fault_o)
    );

    for (genvar g = 0; g < XFD_NUM_LVL; g++) begin : g_level
        xfd_span_counter #(
            .CNT_W (CNT_W)
        ) u_span (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (period_start),
            .miss_i  (miss[g]),
            .dut_i   (dut_bits[g]),
            .count_o (span_cnt[g]),
            .seen_o  (span_seen[g])
        );
    end

    xfd_classifier #(
        .CNT_W (CNT_W)
    ) u_classifier (
        .hi_cnt_i  (span_cnt[XFD_LVL_HI]),
        .lo_cnt_i  (span_cnt[XFD_LVL_LO]),
        .tol_i     (tol_i),
        .hi_seen_i (span_seen[XFD_LVL_HI]),
        .lo_seen_i (span_seen[XFD_LVL_LO]),
        .class_o   (next_cls)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ref_prev = ref_hi_i;
        if (period_start) begin
            st_d.armed = 1'b1;
            if (st_q.armed) begin
                st_d.hi_cnt = span_cnt[XFD_LVL_HI];
                st_d.lo_cnt = span_cnt[XFD_LVL_LO];
                st_d.cls    = next_cls;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ref_prev: 1'b0, armed: 1'b0, hi_cnt: '0, lo_cnt: '0, cls: CLS_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_count_o = st_q.hi_cnt;
    assign lo_count_o = st_q.lo_cnt;
    assign class_o    = st_q.cls;
endmodule

// File: rtl/xfd_checks.sv
module xfd_checks #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             ref_hi_i,
    input logic             ref_lo_i,
    input logic             dut_hi_i,
    input logic             dut_lo_i,
    input logic             fault_o,
    input logic [CNT_W-1:0] hi_count_o,
    input logic [CNT_W-1:0] lo_count_o,
    input logic [2:0]       class_o
);
    logic ref_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_seen_q <= 1'b0;
        end else begin
            ref_seen_q <= ref_hi_i;
        end
    end

    assert_mismatch_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((ref_hi_i != dut_hi_i) || (ref_lo_i != dut_lo_i)) && !clr_i) |=> fault_o);

    assert_fault_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !clr_i) |=> fault_o);

    assert_clear_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !fault_o);

    assert_quiet_no_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ref_hi_i == dut_hi_i) && (ref_lo_i == dut_lo_i) && !fault_o) |=> !fault_o);

    assert_hold_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ref_hi_i && !ref_seen_q) |=>
            ($stable(hi_count_o) && $stable(lo_count_o) && $stable(class_o)));

    assert_class_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        class_o <= 3'd4);

    assert_quiet_class_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (class_o == 3'd0) |-> ((hi_count_o == '0) && (lo_count_o == '0)));
endmodule

bind xing_fault_detector xfd_checks #(.CNT_W(CNT_W)) u_checks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .ref_hi_i   (ref_hi_i),
    .ref_lo_i   (ref_lo_i),
    .dut_hi_i   (dut_hi_i),
    .dut_lo_i   (dut_lo_i),
    .fault_o    (fault_o),
    .hi_count_o (hi_count_o),
    .lo_count_o (lo_count_o),
    .class_o    (class_o)
);

// File: tb/sim_xing_fault_detector.sv
module sim_xing_fault_detector;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int SAT        = (1 << CNT_W) - 1;
    localparam int NONE       = -1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             ref_hi = 1'b0;
    logic             ref_lo = 1'b0;
    logic             dut_hi = 1'b0;
    logic             dut_lo = 1'b0;
    logic [CNT_W-1:0] tol = '0;
    logic             fault;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
    logic [2:0]       cls;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    hi;
        int    lo;
        int    cls;
        string req;
    } exp_t;

    exp_t exp_q[$];
    bit   boundary = 1'b0;

    int cur_hi = 0, cur_lo = 0;
    bit seen_hi = 1'b0, seen_lo = 1'b0;
    bit armed_tb = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xing_fault_detector #(.CNT_W(CNT_W)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .clr_i      (clr),
        .ref_hi_i   (ref_hi),
        .ref_lo_i   (ref_lo),
        .dut_hi_i   (dut_hi),
        .dut_lo_i   (dut_lo),
        .tol_i      (tol),
        .fault_o    (fault),
        .hi_count_o (hi_cnt),
        .lo_count_o (lo_cnt),
        .class_o    (cls)
    );

    task automatic chk(input string req, input string what, input int got, input int expv);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, expv);
        end
    endtask

    function automatic int tb_class(int h, int l, bit sh, bit sl, int t);
        int gap;
        if (!sh || !sl) return 4;
        if (h == 0 && l == 0) return 0;
        gap = (h > l) ? h - l : l - h;
        if (gap <= t) return 1;
        return (h > l) ? 2 : 3;
    endfunction

    // Applies one cycle of samples and updates the bench's own period tally.
    task automatic apply(input bit rh, input bit rl, input bit dh, input bit dl);
        ref_hi = rh; ref_lo = rl; dut_hi = dh; dut_lo = dl;
        if (rh != dh && cur_hi < SAT) cur_hi++;
        if (rl != dl && cur_lo < SAT) cur_lo++;
        if (dh) seen_hi = 1'b1;
        if (dl) seen_lo = 1'b1;
    endtask

    task automatic extra_cycle(input bit dh, input bit dl, input bit c);
        @(negedge clk);
        boundary = 1'b0;
        clr = c;
        apply(1'b0, 1'b0, dh, dl);
    endtask

    // Driver: one reference period; at its first cycle the finished period's
    // expected result is pushed onto the scoreboard.
    task automatic run_period(input int p, input int hs, input int he,
                              input int ls, input int le, input int tolv,
                              input string req);
        for (int c = 0; c < p; c++) begin
            @(negedge clk);
            clr = 1'b0;
            if (c == 0) begin
                tol = tolv[CNT_W-1:0];
                if (armed_tb) begin
                    exp_q.push_back('{cur_hi, cur_lo,
                                      tb_class(cur_hi, cur_lo, seen_hi, seen_lo, tolv), req});
                end
                armed_tb = 1'b1;
                cur_hi = 0; cur_lo = 0; seen_hi = 1'b0; seen_lo = 1'b0;
                boundary = 1'b1;
            end else begin
                boundary = 1'b0;
            end
            apply(c < 6, (c >= p / 2) && (c < p / 2 + 6),
                  (hs != NONE) && (c >= hs) && (c < he),
                  (ls != NONE) && (c >= ls) && (c < le));
        end
    endtask

    // Monitor: pops expectations at period starts, otherwise checks hold.
    initial begin
        exp_t last;
        exp_t e;
        last = '{0, 0, 0, "R3"};
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && boundary && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(e.req, "hi_count", int'(hi_cnt), e.hi);
                chk(e.req, "lo_count", int'(lo_cnt), e.lo);
                chk(e.req, "class", int'(cls), e.cls);
                last = e;
            end else if (rst_n) begin
                // R4 hold between starts; R5 no report at the arming start
                chk(boundary ? "R5" : "R4", "held hi_count", int'(hi_cnt), last.hi);
                chk(boundary ? "R5" : "R4", "held lo_count", int'(lo_cnt), last.lo);
                chk(boundary ? "R5" : "R4", "held class", int'(cls), last.cls);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3", "fault in reset", int'(fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "fault after reset", int'(fault), 0);
        chk("R3", "hi_count after reset", int'(hi_cnt), 0);
        chk("R3", "class after reset", int'(cls), 0);

        // Mismatches before any period start: must set fault, never be counted (R5)
        for (int i = 0; i < 5; i++) extra_cycle(1'b0, 1'b1, 1'b0);
        chk("R1", "fault after pre-roll mismatch", int'(fault), 1);

        run_period(20, 0, 6, 10, 16, 0, "R5");          // arming period, clean
        chk("R2", "fault sticky over clean period", int'(fault), 1);
        extra_cycle(1'b0, 1'b0, 1'b1);
        extra_cycle(1'b0, 1'b0, 1'b0);
        chk("R2", "fault after clear", int'(fault), 0);

        run_period(20, 0, 6, 10, 16, 0, "R10");         // clean
        chk("R1", "no fault on matching samples", int'(fault), 0);
        run_period(20, 2, 8, 12, 18, 0, "R10");         // phase lag by 2
        chk("R1", "fault on phase lag", int'(fault), 1);
        run_period(20, 0, 6, 10, 16, 0, "R7");          // clean
        chk("R2", "fault still sticky", int'(fault), 1);
        extra_cycle(1'b1, 1'b0, 1'b1);                  // clear together with mismatch
        extra_cycle(1'b0, 1'b0, 1'b0);
        chk("R2", "clear beats mismatch", int'(fault), 0);

        run_period(20, 0, 3, 7, 19, 0, "R8");           // A
        run_period(20, 0, 3, 7, 19, 3, "R7");           // B: A at tol 3
        run_period(20, 0, 10, 13, 16, 2, "R8");         // C: B at tol 2
        run_period(20, 0, 6, NONE, NONE, 0, "R8");      // D: C
        run_period(20, NONE, NONE, NONE, NONE, 0, "R9");// E: D
        run_period(20, 0, 6, 10, 16, 0, "R9");          // F: E
        run_period(300, NONE, NONE, 0, 300, 0, "R10");  // G: F
        run_period(20, 0, 6, 10, 16, 0, "R6");          // H: G saturates
        run_period(1, 0, 6, 10, 16, 0, "R10");          // closing start: H
        extra_cycle(1'b0, 1'b0, 1'b0);
        extra_cycle(1'b0, 1'b0, 1'b0);
        chk("R4", "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule